// File: doc/BRIEF.md
# Multicycle 32-bit Integer Core

This block is a compact 32-bit processor. It executes a reduced load/store instruction set, one instruction at a time. Each instruction takes two clock cycles. In the first cycle the core reads the word at the program counter from a 64-word code memory and advances the counter by four. In the second cycle it decodes the word, reads two operands from a 32-entry register file, computes a result, and then does one of three things: writes the result back, accesses a 64-word data memory, or redirects the program counter. The core does no multiply or divide, raises no exceptions and executes no delay slot after a branch or jump.

The surrounding logic uses the core as follows. While the core is idle or halted, it fills the code and data memories through a simple write port. It then pulses `start`, which reinitialises the register file and the program counter and begins execution. It waits for `done`, then reads data memory back through a peek port. Execution stops when an instruction leaves the program counter at zero. A jump to address zero, a jump-register through a zero register, or an undecodable instruction all cause this. The number of executed instructions is reported on `retired`.

Top module: `nano_core`

## Requirements
- R1: After reset, and again on each `start` pulse while the core is not busy, the program counter becomes 0x00400000, register 29 becomes 0x7FFFEFFC, every other register becomes 0 and `retired` becomes 0. After reset, `done` and `busy` are low.
- R2: An instruction holds opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, shamt in 10:6, funct in 5:0, the immediate in 15:0 and the jump target in 25:0. Opcode 0 selects a register-register operation by funct: 33 add, 35 subtract (rs minus rt), 36 and, 37 or, 38 xor. The result is written to rd.
- R3: For every immediate operation the 16-bit immediate is zero-extended. The opcodes are 9 add, 10 signed set-less-than, 11 unsigned set-less-than, 12 and, 13 or, 14 xor and 15 load-upper, which places the immediate in bits 31:16. The result is written to rt.
- R4: The shifts shift rt. Funct 0 shifts left and funct 2 shifts right, both by shamt. Funct 4 shifts left and funct 6 shifts right, both by the low 5 bits of rs. Right shifts fill with zeros. Funct 42 is a signed compare and funct 43 an unsigned compare, each giving 1 or 0. Funct 16 and 18 write 0.
- R5: Opcode 4 branches when rs equals rt, opcode 5 when they differ, and opcode 1 when bit 31 of rs is clear. A taken branch goes to the branch's own address plus the zero-extended immediate times four. The instruction after a taken branch is not executed.
- R6: Opcode 2 loads the program counter with target times four, with no upper bits kept. Opcode 3 does the same and also writes the address of the following instruction into register 31. Funct 8 loads the program counter from rs.
- R7: Opcode 35 loads and opcode 43 stores a word at byte address rs plus the zero-extended immediate. Only address bits 7:2 select the word, so accesses wrap within 256 bytes.
- R8: Register 0 always reads as zero, whatever an instruction writes to it.
- R9: An unknown opcode or an unknown funct under opcode 0 sets the program counter to zero. Whenever the program counter is zero after an instruction, the core halts without fetching again.
- R10: `done` rises when the core halts and stays high until the next `start`. The cycle after `start`, it is low and `busy` is high.
- R11: `retired` increments by one for every executed instruction, including the one that halts the core, and holds while the core is halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that reinitialises the core and begins execution; ignored while busy |
| busy | output | 1 | High while instructions are executing |
| done | output | 1 | High from halt until the next start |
| retired | output | 32 | Count of instructions executed since start |
| load_we | input | 1 | Memory fill write strobe, honoured only while not busy |
| load_code | input | 1 | 1 selects the code memory, 0 the data memory, for a fill write |
| load_addr | input | 6 | Word index for a fill write |
| load_data | input | 32 | Word written by a fill write |
| peek_addr | input | 6 | Data memory word index read back while not busy |
| peek_data | output | 32 | Data memory word at `peek_addr` |

## Verification
The bench looks for the corner cases that a core built on common sign-extension habits would get wrong. An immediate of 0xFFFF added to a register must give a large positive sum, not a decrement. A signed compare of 0x80000000 against 1 must give 1. A variable shift by 36 must act as a shift by 4. A taken branch must skip the next word, and its target must be counted from the branch itself; a core that measured the target from the following word would land one instruction late and store a poisoned marker. The link value must be read back through memory. A store at byte 0x134 and a load at 0x104 must wrap onto low words. A second `start` must clear registers that an earlier program left non-zero. An undecodable word must stop the run before a following store can overwrite a preloaded sentinel.

// File: rtl/nano_pkg.sv
package nano_pkg;
  localparam int XLEN   = 32;
  localparam int NREGS  = 32;
  localparam int RIDX_W = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_HALT} state_t;

  localparam logic [5:0] OP_RTYPE = 6'd0,  OP_REGIMM = 6'd1, OP_J    = 6'd2,
                         OP_JAL   = 6'd3,  OP_BEQ    = 6'd4, OP_BNE  = 6'd5,
                         OP_ADDIU = 6'd9,  OP_SLTI   = 6'd10, OP_SLTIU = 6'd11,
                         OP_ANDI  = 6'd12, OP_ORI    = 6'd13, OP_XORI = 6'd14,
                         OP_LUI   = 6'd15, OP_LW     = 6'd35, OP_SW   = 6'd43;

  localparam logic [5:0] FN_SLL  = 6'd0,  FN_SRL  = 6'd2,  FN_SLLV = 6'd4,
                         FN_SRLV = 6'd6,  FN_JR   = 6'd8,  FN_MFHI = 6'd16,
                         FN_MFLO = 6'd18, FN_ADDU = 6'd33, FN_SUBU = 6'd35,
                         FN_AND  = 6'd36, FN_OR   = 6'd37, FN_XOR  = 6'd38,
                         FN_SLT  = 6'd42, FN_SLTU = 6'd43;

  typedef enum logic [3:0] {
    A_ADD, A_SUB, A_AND, A_OR, A_XOR, A_SLL, A_SRL, A_SLT, A_SLTU, A_LUI, A_ZERO
  } alu_op_t;

  typedef struct packed {
    alu_op_t           op;
    logic              use_imm;
    logic              use_shamt;
    logic [RIDX_W-1:0] dst;
    logic              wen;
    logic              ld;
    logic              st;
    logic              beq;
    logic              bne;
    logic              bgez;
    logic              jmp;
    logic              jal;
    logic              jr;
    logic              bad;
  } ctrl_t;

  // Arithmetic kept in one function: b is the shifted operand, a[4:0] the amount.
  function automatic logic [XLEN-1:0] alu_eval(alu_op_t op, logic [XLEN-1:0] a,
                                               logic [XLEN-1:0] b);
    case (op)
      A_ADD:   return a + b;
      A_SUB:   return a - b;
      A_AND:   return a & b;
      A_OR:    return a | b;
      A_XOR:   return a ^ b;
      A_SLL:   return b << a[4:0];
      A_SRL:   return b >> a[4:0];
      A_SLT:   return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      A_SLTU:  return {{(XLEN-1){1'b0}}, (a < b)};
      A_LUI:   return {b[15:0], 16'h0000};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/nano_decode.sv
module nano_decode
  import nano_pkg::*;
(
  input  logic [5:0]        opc,
  input  logic [5:0]        fn,
  input  logic [RIDX_W-1:0] rt,
  input  logic [RIDX_W-1:0] rd,
  output ctrl_t             ctl
);
  always_comb begin
    ctl     = '0;
    ctl.op  = A_ADD;
    ctl.dst = rt;
    case (opc)
      OP_RTYPE: begin
        ctl.dst = rd;
        ctl.wen = 1'b1;
        case (fn)
          FN_SLL:  begin ctl.op = A_SLL; ctl.use_shamt = 1'b1; end
          FN_SRL:  begin ctl.op = A_SRL; ctl.use_shamt = 1'b1; end
          FN_SLLV: ctl.op = A_SLL;
          FN_SRLV: ctl.op = A_SRL;
          FN_JR:   begin ctl.wen = 1'b0; ctl.jr = 1'b1; end
          FN_MFHI, FN_MFLO: ctl.op = A_ZERO;
          FN_ADDU: ctl.op = A_ADD;
          FN_SUBU: ctl.op = A_SUB;
          FN_AND:  ctl.op = A_AND;
          FN_OR:   ctl.op = A_OR;
          FN_XOR:  ctl.op = A_XOR;
          FN_SLT:  ctl.op = A_SLT;
          FN_SLTU: ctl.op = A_SLTU;
          default: begin ctl.wen = 1'b0; ctl.bad = 1'b1; end
        endcase
      end
      OP_J:      ctl.jmp = 1'b1;
      OP_JAL:    begin ctl.jmp = 1'b1; ctl.jal = 1'b1; ctl.wen = 1'b1; ctl.dst = 5'd31; end
      OP_BEQ:    ctl.beq = 1'b1;
      OP_BNE:    ctl.bne = 1'b1;
      OP_REGIMM: ctl.bgez = 1'b1;
      OP_ADDIU:  begin ctl.op = A_ADD;  ctl.use_imm = 1'b1; ctl.wen = 1'b1; end
      OP_SLTI:   begin ctl.op = A_SLT;  ctl.use_imm = 1'b1; ctl.wen = 1'b1; end
      OP_SLTIU:  begin ctl.op = A_SLTU; ctl.use_imm = 1'b1; ctl.wen = 1'b1; end
      OP_ANDI:   begin ctl.op = A_AND;  ctl.use_imm = 1'b1; ctl.wen = 1'b1; end
      OP_ORI:    begin ctl.op = A_OR;   ctl.use_imm = 1'b1; ctl.wen = 1'b1; end
      OP_XORI:   begin ctl.op = A_XOR;  ctl.use_imm = 1'b1; ctl.wen = 1'b1; end
      OP_LUI:    begin ctl.op = A_LUI;  ctl.use_imm = 1'b1; ctl.wen = 1'b1; end
      OP_LW:     begin ctl.ld = 1'b1;   ctl.use_imm = 1'b1; ctl.wen = 1'b1; end
      OP_SW:     begin ctl.st = 1'b1;   ctl.use_imm = 1'b1; end
      default:   ctl.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/nano_regs.sv
module nano_regs
  import nano_pkg::*;
#(
  parameter int              SP_IDX  = 29,
  parameter logic [XLEN-1:0] SP_INIT = 32'h7FFF_EFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              we,
  input  logic [RIDX_W-1:0] waddr,
  input  logic [XLEN-1:0]   wdata,
  input  logic [RIDX_W-1:0] raddr_a,
  input  logic [RIDX_W-1:0] raddr_b,
  output logic [XLEN-1:0]   rdata_a,
  output logic [XLEN-1:0]   rdata_b
);
  logic [XLEN-1:0] regv [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regv[g] = '0;
    end else begin : g_flop
      localparam logic [XLEN-1:0] INIT = (g == SP_IDX) ? SP_INIT : '0;
      logic [XLEN-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          r <= INIT;
        else if (clear)                      r <= INIT;
        else if (we && waddr == RIDX_W'(g))  r <= wdata;
      end
      assign regv[g] = r;
    end
  end

  assign rdata_a = regv[raddr_a];
  assign rdata_b = regv[raddr_b];
endmodule

// File: rtl/nano_ram.sv
module nano_ram
  import nano_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [XLEN-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/nano_core.sv
module nano_core
  import nano_pkg::*;
#(
  parameter int              MEM_AW   = 6,
  parameter int              CNT_W    = 32,
  parameter logic [XLEN-1:0] BOOT_PC  = 32'h0040_0000,
  parameter logic [XLEN-1:0] STACK_SP = 32'h7FFF_EFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  retired,
  input  logic              load_we,
  input  logic              load_code,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [XLEN-1:0]   load_data,
  input  logic [MEM_AW-1:0] peek_addr,
  output logic [XLEN-1:0]   peek_data
);
  localparam int WSEL_HI = MEM_AW + 1;

  state_t          st;
  logic [XLEN-1:0] pc, ir, next_pc;
  logic            exec_fire, launch;

  assign busy      = (st == ST_FETCH) || (st == ST_EXEC);
  assign done      = (st == ST_HALT);
  assign exec_fire = (st == ST_EXEC);
  assign launch    = start && !busy;

  // Instruction fields
  logic [5:0]        f_op, f_fn;
  logic [RIDX_W-1:0] f_rs, f_rt, f_rd, f_sh;
  logic [15:0]       f_imm;
  logic [25:0]       f_tgt;
  assign f_op  = ir[31:26];
  assign f_rs  = ir[25:21];
  assign f_rt  = ir[20:16];
  assign f_rd  = ir[15:11];
  assign f_sh  = ir[10:6];
  assign f_fn  = ir[5:0];
  assign f_imm = ir[15:0];
  assign f_tgt = ir[25:0];

  ctrl_t ctl;
  nano_decode u_dec (.opc(f_op), .fn(f_fn), .rt(f_rt), .rd(f_rd), .ctl(ctl));

  // Register file
  logic [XLEN-1:0] rs_val, rt_val, rf_wdata, alu_a, alu_b, alu_y, d_rdata;
  logic            rf_we;
  assign rf_we = exec_fire && ctl.wen;
  nano_regs #(.SP_IDX(29), .SP_INIT(STACK_SP)) u_regs (
    .clk(clk), .rst_n(rst_n), .clear(launch), .we(rf_we), .waddr(ctl.dst),
    .wdata(rf_wdata), .raddr_a(f_rs), .raddr_b(f_rt),
    .rdata_a(rs_val), .rdata_b(rt_val));

  // Execute
  assign alu_a = ctl.use_shamt ? {{(XLEN-RIDX_W){1'b0}}, f_sh} : rs_val;
  assign alu_b = ctl.use_imm   ? {16'h0000, f_imm}             : rt_val;
  assign alu_y = alu_eval(ctl.op, alu_a, alu_b);
  assign rf_wdata = ctl.jal ? pc : (ctl.ld ? d_rdata : alu_y);

  // Control flow: pc already holds the address of the next word
  logic            br_taken;
  logic [XLEN-1:0] br_tgt, jmp_tgt;
  assign br_taken = (ctl.beq  && (rs_val == rt_val)) ||
                    (ctl.bne  && (rs_val != rt_val)) ||
                    (ctl.bgez && !rs_val[XLEN-1]);
  assign br_tgt   = pc - 32'd4 + {14'b0, f_imm, 2'b00};
  assign jmp_tgt  = {4'b0000, f_tgt, 2'b00};

  always_comb begin
    if (ctl.bad)      next_pc = '0;
    else if (ctl.jr)  next_pc = rs_val;
    else if (ctl.jmp) next_pc = jmp_tgt;
    else if (br_taken) next_pc = br_tgt;
    else              next_pc = pc;
  end

  // Memories
  logic [XLEN-1:0]   code_word;
  logic              c_we, d_we;
  logic [MEM_AW-1:0] d_waddr, d_raddr;
  logic [XLEN-1:0]   d_wdata;
  assign c_we    = !busy && load_we && load_code;
  assign d_we    = busy ? (exec_fire && ctl.st) : (load_we && !load_code);
  assign d_waddr = busy ? alu_y[WSEL_HI:2] : load_addr;
  assign d_wdata = busy ? rt_val : load_data;
  assign d_raddr = busy ? alu_y[WSEL_HI:2] : peek_addr;
  assign peek_data = d_rdata;

  nano_ram #(.AW(MEM_AW)) u_code (
    .clk(clk), .we(c_we), .waddr(load_addr), .wdata(load_data),
    .raddr(pc[WSEL_HI:2]), .rdata(code_word));
  nano_ram #(.AW(MEM_AW)) u_data (
    .clk(clk), .we(d_we), .waddr(d_waddr), .wdata(d_wdata),
    .raddr(d_raddr), .rdata(d_rdata));

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pc      <= BOOT_PC;
      ir      <= '0;
      retired <= '0;
    end else begin
      case (st)
        ST_FETCH: begin
          ir <= code_word;
          pc <= pc + 32'd4;
          st <= ST_EXEC;
        end
        ST_EXEC: begin
          pc      <= next_pc;
          retired <= retired + 1'b1;
          st      <= (next_pc == '0) ? ST_HALT : ST_FETCH;
        end
        default: begin
          if (start) begin
            pc      <= BOOT_PC;
            retired <= '0;
            st      <= ST_FETCH;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nano_core_chk.sv
module nano_core_chk
  import nano_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  retired,
  input logic              exec_fire,
  input logic [XLEN-1:0]   next_pc,
  input logic [RIDX_W-1:0] rs_idx,
  input logic [XLEN-1:0]   rs_val
);
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && retired == '0)); // R1
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_idx == '0) |-> (rs_val == '0)); // R8
  AST_HALT_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && next_pc == '0) |=> done); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (retired == $past(retired) || retired == $past(retired) + 1'b1)); // R11
  AST_RETIRE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(retired)); // R11
endmodule

bind nano_core nano_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .retired(retired), .exec_fire(exec_fire), .next_pc(next_pc),
  .rs_idx(f_rs), .rs_val(rs_val));

// File: tb/nano_core_bench.sv
module nano_core_bench;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic        load_we = 1'b0, load_code = 1'b0;
  logic [5:0]  load_addr = '0, peek_addr = '0;
  logic [31:0] load_data = '0;
  logic        busy, done;
  logic [31:0] retired, peek_data;
  int total = 0, bad = 0;
  logic [31:0] prog [64];

  always #4 clk = ~clk;

  nano_core u_nano_core (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .retired(retired), .load_we(load_we), .load_code(load_code),
    .load_addr(load_addr), .load_data(load_data),
    .peek_addr(peek_addr), .peek_data(peek_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(int op, int tgt);
    return {6'(op), 26'(tgt)};
  endfunction
  function automatic logic [31:0] sw(int rt, int off);
    return enc_i(43, 0, rt, 16'(off));
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
  endtask

  task automatic load_prog();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      load_we = 1'b1; load_code = 1'b1; load_addr = 6'(i); load_data = prog[i];
    end
    @(negedge clk);
    load_we = 1'b0; load_code = 1'b0;
  endtask

  task automatic put_data(input int a, input logic [31:0] v);
    @(negedge clk);
    load_we = 1'b1; load_code = 1'b0; load_addr = 6'(a); load_data = v;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic peek_chk(input string tag, input int a, input logic [31:0] exp);
    @(negedge clk);
    peek_addr = 6'(a);
    #1;
    chk(tag, peek_data, exp);
  endtask

  task automatic run(input int limit);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 done low after start", {31'b0, done}, 32'd0);
    chk("R1 busy and count cleared after start", {busy, retired[30:0]}, 32'h8000_0000);
    for (int c = 0; c < limit && !done; c++) @(negedge clk);
    chk("R9 core halted", {31'b0, done}, 32'd1);
  endtask

  task automatic test_reset();
    chk("R1 reset done", {31'b0, done}, 32'd0);
    chk("R1 reset busy", {31'b0, busy}, 32'd0);
    chk("R1 reset retired", retired, 32'd0);
  endtask

  task automatic test_alu();
    clear_prog();
    prog[0]  = enc_i(13, 0, 1, 16'h00F0);
    prog[1]  = enc_i(15, 0, 2, 16'h8000);
    prog[2]  = enc_i(9, 1, 3, 16'hFFFF);
    prog[3]  = enc_r(1, 2, 4, 0, 35);
    prog[4]  = enc_r(2, 1, 5, 0, 42);
    prog[5]  = enc_r(2, 1, 6, 0, 43);
    prog[6]  = enc_r(0, 2, 7, 4, 2);
    prog[7]  = enc_i(13, 0, 9, 16'h0024);
    prog[8]  = enc_r(9, 1, 8, 0, 4);
    prog[9]  = enc_i(10, 2, 10, 16'h0001);
    prog[10] = enc_i(11, 2, 11, 16'h0001);
    prog[11] = enc_i(9, 1, 0, 16'h0005);
    prog[12] = enc_r(0, 0, 17, 0, 16);
    prog[13] = enc_r(4, 1, 15, 0, 38);
    prog[14] = enc_i(14, 1, 16, 16'h00FF);
    prog[15] = sw(3, 0);   prog[16] = sw(4, 4);   prog[17] = sw(5, 8);
    prog[18] = sw(6, 12);  prog[19] = sw(7, 16);  prog[20] = sw(8, 20);
    prog[21] = sw(10, 24); prog[22] = sw(11, 28); prog[23] = sw(29, 32);
    prog[24] = sw(0, 36);  prog[25] = sw(15, 40); prog[26] = sw(16, 44);
    prog[27] = enc_i(13, 0, 13, 16'h0134);
    prog[28] = enc_i(43, 13, 1, 16'h0000);
    prog[29] = enc_i(35, 0, 14, 16'h0104);
    prog[30] = sw(14, 48);
    prog[31] = enc_j(2, 0);
    load_prog();
    run(2000);
    chk("R11 alu program count", retired, 32'd32);
    peek_chk("R3 addiu zero-extends", 0, 32'h0001_00EF);
    peek_chk("R2 subu", 1, 32'h8000_00F0);
    peek_chk("R4 slt signed", 2, 32'd1);
    peek_chk("R4 sltu unsigned", 3, 32'd0);
    peek_chk("R4 srl logical", 4, 32'h0800_0000);
    peek_chk("R4 sllv low five bits", 5, 32'h0000_0F00);
    peek_chk("R3 slti signed", 6, 32'd1);
    peek_chk("R3 sltiu unsigned", 7, 32'd0);
    peek_chk("R1 stack register init", 8, 32'h7FFF_EFFC);
    peek_chk("R8 r0 stays zero", 9, 32'd0);
    peek_chk("R2 xor", 10, 32'h8000_0000);
    peek_chk("R3 xori", 11, 32'h0000_000F);
    peek_chk("R7 load wraps", 12, 32'h8000_00F0);
    peek_chk("R7 store wraps", 13, 32'h0000_00F0);
  endtask

  task automatic test_flow();
    clear_prog();
    prog[0]  = enc_i(13, 0, 1, 16'h0005);
    prog[1]  = enc_i(13, 0, 2, 16'h0005);
    prog[2]  = enc_i(4, 1, 2, 16'h0002);
    prog[3]  = enc_i(13, 0, 3, 16'h0BAD);
    prog[4]  = enc_i(5, 1, 2, 16'h0002);
    prog[5]  = enc_i(13, 0, 4, 16'h0011);
    prog[6]  = enc_i(1, 1, 0, 16'h0002);
    prog[7]  = enc_i(13, 0, 4, 16'h0BAD);
    prog[8]  = enc_i(15, 0, 5, 16'h8000);
    prog[9]  = enc_i(1, 5, 0, 16'h0002);
    prog[10] = enc_i(13, 0, 6, 16'h0022);
    prog[11] = enc_j(3, 14);
    prog[12] = sw(31, 0);
    prog[13] = enc_j(2, 16);
    prog[14] = enc_i(13, 0, 7, 16'h0033);
    prog[15] = enc_r(31, 0, 0, 0, 8);
    prog[16] = sw(3, 4); prog[17] = sw(4, 8); prog[18] = sw(6, 12); prog[19] = sw(7, 16);
    prog[20] = enc_j(2, 0);
    load_prog();
    run(2000);
    chk("R11 flow program count", retired, 32'd19);
    peek_chk("R6 jal link value", 0, 32'h0040_0030);
    peek_chk("R5 beq skips next word", 1, 32'd0);
    peek_chk("R5 bne not taken and bgez taken", 2, 32'h11);
    peek_chk("R5 bgez not taken on negative", 3, 32'h22);
    peek_chk("R6 jump target and jr return", 4, 32'h33);
  endtask

  task automatic test_bad_opcode();
    clear_prog();
    prog[0] = sw(7, 8);
    prog[1] = enc_i(13, 0, 1, 16'h0007);
    prog[2] = sw(1, 0);
    prog[3] = 32'hFC00_0000;
    prog[4] = sw(1, 4);
    load_prog();
    put_data(1, 32'h0000_DEAD);
    put_data(2, 32'h0000_5555);
    run(2000);
    chk("R9 unknown opcode count", retired, 32'd4);
    repeat (5) @(negedge clk);
    chk("R10 done held while idle", {31'b0, done}, 32'd1);
    chk("R11 count held after halt", retired, 32'd4);
    peek_chk("R9 no store after unknown opcode", 1, 32'h0000_DEAD);
    peek_chk("R1 start clears earlier registers", 2, 32'd0);
    peek_chk("R7 plain store", 0, 32'd7);
  endtask

  task automatic test_bad_funct();
    clear_prog();
    prog[0] = enc_i(13, 0, 1, 16'h0009);
    prog[1] = enc_r(0, 0, 0, 0, 63);
    prog[2] = sw(1, 0);
    load_prog();
    put_data(0, 32'h0000_1234);
    run(2000);
    chk("R9 unknown funct count", retired, 32'd2);
    peek_chk("R9 no store after unknown funct", 0, 32'h0000_1234);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_alu();
    test_flow();
    test_bad_opcode();
    test_bad_funct();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule